// File: doc/BRIEF.md
# USB Slave-FIFO Width Bridge

This block connects an external USB peripheral chip, run in synchronous slave-FIFO mode, to a 32-bit on-chip streaming datapath. Toward the chip it owns a 16-bit data bus, which appears here as separate input, output and drive-enable lanes. It also drives a read strobe, a write strobe, an output-enable, a packet-commit strobe and a two-bit endpoint select. It watches two flags: the empty flag of the OUT endpoint and the full flag of the IN endpoint. Every strobe and flag is active high.

Data from the host is read from the OUT endpoint one 16-bit half per interface clock. Pairs of halves are packed into 32-bit words and handed to a receive stream in the system clock domain. Words from a transmit stream are split into halves and written into the IN endpoint. On request from the system side, a packet-commit pulse closes a short IN packet.

A small gray-pointer FIFO in each direction carries words between the interface clock (30 to 48 MHz) and the faster system clock. Each clock domain has its own active-low reset, which asserts asynchronously and is released in step with that domain's clock.

Top module: `usbfifo_bridge`

## Requirements
- R1: While reset is held and just after its release, `fx_rd`, `fx_wr`, `fx_oe`, `fx_commit` and `fd_drive` are low, `rx_valid` is low and `tx_ready` is high.
- R2: `fx_rd` is high only while `fx_empty` is low, `fx_oe` is high and `fx_addr` is 2'b00 (OUT endpoint). `fx_oe` is high only in read cycles.
- R3: Each received word is {second half, first half}: the half read first from the chip is bits 15:0 of `rx_data`, and the half read next is bits 31:16.
- R4: `fx_wr` is high only while `fx_full` is low, `fd_drive` is high and `fx_addr` is 2'b10 (IN endpoint). Bits 15:0 of each transmit word go out on `fd_out` before bits 31:16.
- R5: `fx_oe` and `fd_drive` are never high in the same cycle.
- R6: In any interface cycle where `fx_addr` differs from its value in the previous cycle, `fx_rd`, `fx_wr` and `fx_commit` are all low.
- R7: With OUT data present and the receive stream always ready, a burst of N halves is read with `fx_rd` high on N consecutive interface clocks.
- R8: With the IN endpoint not full and the transmit stream fed continuously, N words go out with `fx_wr` high on 2N consecutive interface clocks.
- R9: While `fx_full` is high no half is written, and once it drops every pending word is delivered intact and in order.
- R10: With `rx_ready` held low, the block reads exactly 2·2^FIFO_AW + 1 halves and then holds `fx_rd` low, with `rx_valid` high. No data is lost once `rx_ready` returns.
- R11: Each `commit_req` pulse produces exactly one single-cycle `fx_commit`. It is issued with `fx_addr` 2'b10, only while `fx_full` is low, and only after all earlier transmit words have been written to the chip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| if_clk | input | 1 | Interface clock shared with the chip |
| if_arst_n | input | 1 | Active-low reset, interface domain |
| sys_clk | input | 1 | System clock |
| sys_arst_n | input | 1 | Active-low reset, system domain |
| fd_in | input | 16 | Data bus as driven by the chip |
| fd_out | output | 16 | Data bus as driven by this block |
| fd_drive | output | 1 | Enables this block's bus drivers |
| fx_rd | output | 1 | Read strobe, pops one half from the OUT endpoint |
| fx_wr | output | 1 | Write strobe, pushes one half into the IN endpoint |
| fx_oe | output | 1 | Lets the chip drive the data bus |
| fx_commit | output | 1 | Commits a short IN packet |
| fx_addr | output | 2 | Endpoint select: 00 OUT, 10 IN |
| fx_empty | input | 1 | OUT endpoint empty flag |
| fx_full | input | 1 | IN endpoint full flag |
| rx_data | output | 32 | Packed receive word |
| rx_valid | output | 1 | Receive word available |
| rx_ready | input | 1 | Receive word accepted |
| tx_data | input | 32 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word accepted |
| commit_req | input | 1 | One-cycle request to close the IN packet |

## Verification
A stuck half-select flop in either packer swaps or shifts halves. This shows up on the very next `rx_data` word or the next pair of IN writes, so the bench compares every word against lists it builds itself. A sequencer that skips its settling state or leaves a strobe open against a flag shows up on the strobe pins in that same interface cycle, and the bench counts each such cycle. Lost throughput or a wrong backpressure limit appears as a shorter strobe run, or as a different count of halves taken while the receive side is stalled. Both are measured in the directed bursts.

// File: rtl/usbfifo_pkg.sv
`timescale 1ns/1ps
package usbfifo_pkg;
  // endpoint select codes driven on fx_addr
  localparam logic [1:0] ADDR_OUT_EP = 2'b00;
  localparam logic [1:0] ADDR_IN_EP  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_READ,
    ST_WR_SETUP,
    ST_WRITE,
    ST_COMMIT
  } ctl_state_e;
endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cdc_sync.sv
`timescale 1ns/1ps
module cdc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/async_fifo.sv
`timescale 1ns/1ps
module async_fifo #(
  parameter int unsigned W           = 32,
  parameter int unsigned AW          = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wen,
  input  logic [W-1:0] wdata,
  output logic         wfull,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         ren,
  output logic [W-1:0] rdata,
  output logic         rempty
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin_q, wbin_d, wgray_q, wgray_d, rgray_w;
  logic [AW:0]  rbin_q, rbin_d, rgray_q, rgray_d, wgray_r;
  logic         wr_fire, rd_fire;

  assign wr_fire = wen && !wfull;
  assign rd_fire = ren && !rempty;

  // write side
  always_comb begin
    wbin_d  = wbin_q + {{AW{1'b0}}, wr_fire};
    wgray_d = (wbin_d >> 1) ^ wbin_d;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[wbin_q[AW-1:0]] <= wdata;
  end

  cdc_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w)
  );

  assign wfull = (wgray_q == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});

  // read side
  always_comb begin
    rbin_d  = rbin_q + {{AW{1'b0}}, rd_fire};
    rgray_d = (rbin_d >> 1) ^ rbin_d;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  cdc_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r)
  );

  assign rempty = (rgray_q == wgray_r);
  assign rdata  = mem[rbin_q[AW-1:0]];
endmodule

// File: rtl/fx_ctrl.sv
`timescale 1ns/1ps
module fx_ctrl
  import usbfifo_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fx_empty,
  input  logic                fx_full,
  input  logic [HALF_W-1:0]   fd_in,
  output logic [HALF_W-1:0]   fd_out,
  output logic                fd_drive,
  output logic                fx_rd,
  output logic                fx_wr,
  output logic                fx_oe,
  output logic                fx_commit,
  output logic [1:0]          fx_addr,
  output logic [2*HALF_W-1:0] rx_wdata,
  output logic                rx_wen,
  input  logic                rx_wfull,
  input  logic [2*HALF_W-1:0] tx_rdata,
  output logic                tx_ren,
  input  logic                tx_rempty,
  input  logic                commit_tgl
);
  ctl_state_e        state_q, state_d;
  logic [1:0]        addr_q, addr_d;
  logic              rx_half_q, tx_half_q;
  logic [HALF_W-1:0] rx_lo_q;
  logic              pend_q, pend_d, seen_q;
  logic              commit_evt, commit_go, rd_ok, wr_ok;

  // a half may be read when the chip has data and, for an upper half,
  // the packed word has somewhere to go
  assign rd_ok      = !fx_empty && (!rx_half_q || !rx_wfull);
  assign wr_ok      = !fx_full && !tx_rempty;
  assign commit_evt = commit_tgl ^ seen_q;
  assign commit_go  = pend_q && !tx_half_q && tx_rempty;
  assign pend_d     = commit_evt || (pend_q && !fx_commit);

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    fx_rd     = 1'b0;
    fx_wr     = 1'b0;
    fx_oe     = 1'b0;
    fx_commit = 1'b0;
    fd_drive  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (commit_go) begin
          if (addr_q == ADDR_IN_EP) state_d = ST_COMMIT;
          else begin
            addr_d  = ADDR_IN_EP;
            state_d = ST_WR_SETUP;
          end
        end else if (rd_ok) begin
          if (addr_q == ADDR_OUT_EP) state_d = ST_READ;
          else begin
            addr_d  = ADDR_OUT_EP;
            state_d = ST_RD_SETUP;
          end
        end else if (wr_ok) begin
          if (addr_q == ADDR_IN_EP) state_d = ST_WRITE;
          else begin
            addr_d  = ADDR_IN_EP;
            state_d = ST_WR_SETUP;
          end
        end
      end
      ST_RD_SETUP: state_d = ST_READ;
      ST_READ: begin
        fx_oe = 1'b1;
        fx_rd = rd_ok;
        if (!rd_ok) state_d = ST_IDLE;
      end
      ST_WR_SETUP: state_d = commit_go ? ST_COMMIT : ST_WRITE;
      ST_WRITE: begin
        fd_drive = 1'b1;
        fx_wr    = wr_ok;
        if (!wr_ok) state_d = ST_IDLE;
      end
      ST_COMMIT: begin
        fx_commit = !fx_full;
        if (!fx_full) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= ADDR_OUT_EP;
      rx_half_q <= 1'b0;
      rx_lo_q   <= '0;
      tx_half_q <= 1'b0;
      pend_q    <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      pend_q  <= pend_d;
      seen_q  <= commit_tgl;
      if (fx_rd) begin
        rx_half_q <= !rx_half_q;
        if (!rx_half_q) rx_lo_q <= fd_in;
      end
      if (fx_wr) tx_half_q <= !tx_half_q;
    end
  end

  assign fx_addr  = addr_q;
  assign fd_out   = tx_half_q ? tx_rdata[2*HALF_W-1:HALF_W] : tx_rdata[HALF_W-1:0];
  assign rx_wen   = fx_rd && rx_half_q;
  assign rx_wdata = {fd_in, rx_lo_q};
  assign tx_ren   = fx_wr && tx_half_q;
endmodule

// File: rtl/usbfifo_bridge.sv
`timescale 1ns/1ps
module usbfifo_bridge #(
  parameter int unsigned HALF_W      = 16,
  parameter int unsigned FIFO_AW     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                if_clk,
  input  logic                if_arst_n,
  input  logic                sys_clk,
  input  logic                sys_arst_n,
  input  logic [HALF_W-1:0]   fd_in,
  output logic [HALF_W-1:0]   fd_out,
  output logic                fd_drive,
  output logic                fx_rd,
  output logic                fx_wr,
  output logic                fx_oe,
  output logic                fx_commit,
  output logic [1:0]          fx_addr,
  input  logic                fx_empty,
  input  logic                fx_full,
  output logic [2*HALF_W-1:0] rx_data,
  output logic                rx_valid,
  input  logic                rx_ready,
  input  logic [2*HALF_W-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic                commit_req
);
  localparam int unsigned WORD_W = 2 * HALF_W;

  logic              if_rst_n, sys_rst_n;
  logic [WORD_W-1:0] rx_wdata, tx_rdata;
  logic              rx_wen, rx_wfull, rx_rempty;
  logic              tx_ren, tx_rempty, tx_wfull;
  logic              tgl_q, tgl_if;

  rst_sync #(.STAGES(SYNC_STAGES)) u_if_rst (
    .clk(if_clk), .arst_n(if_arst_n), .rst_n(if_rst_n)
  );
  rst_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk(sys_clk), .arst_n(sys_arst_n), .rst_n(sys_rst_n)
  );

  // commit request crosses as a level toggle
  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n)      tgl_q <= 1'b0;
    else if (commit_req) tgl_q <= !tgl_q;
  end

  cdc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk(if_clk), .rst_n(if_rst_n), .d(tgl_q), .q(tgl_if)
  );

  async_fifo #(.W(WORD_W), .AW(FIFO_AW), .SYNC_STAGES(SYNC_STAGES)) u_rx_fifo (
    .wclk(if_clk), .wrst_n(if_rst_n), .wen(rx_wen), .wdata(rx_wdata), .wfull(rx_wfull),
    .rclk(sys_clk), .rrst_n(sys_rst_n), .ren(rx_ready), .rdata(rx_data), .rempty(rx_rempty)
  );

  async_fifo #(.W(WORD_W), .AW(FIFO_AW), .SYNC_STAGES(SYNC_STAGES)) u_tx_fifo (
    .wclk(sys_clk), .wrst_n(sys_rst_n), .wen(tx_valid), .wdata(tx_data), .wfull(tx_wfull),
    .rclk(if_clk), .rrst_n(if_rst_n), .ren(tx_ren), .rdata(tx_rdata), .rempty(tx_rempty)
  );

  assign rx_valid = !rx_rempty;
  assign tx_ready = !tx_wfull;

  fx_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .clk(if_clk), .rst_n(if_rst_n),
    .fx_empty(fx_empty), .fx_full(fx_full), .fd_in(fd_in),
    .fd_out(fd_out), .fd_drive(fd_drive),
    .fx_rd(fx_rd), .fx_wr(fx_wr), .fx_oe(fx_oe), .fx_commit(fx_commit), .fx_addr(fx_addr),
    .rx_wdata(rx_wdata), .rx_wen(rx_wen), .rx_wfull(rx_wfull),
    .tx_rdata(tx_rdata), .tx_ren(tx_ren), .tx_rempty(tx_rempty),
    .commit_tgl(tgl_if)
  );
endmodule

// File: rtl/usbfifo_bridge_chk.sv
`timescale 1ns/1ps
module usbfifo_bridge_chk (
  input logic       if_clk,
  input logic       if_arst_n,
  input logic       fx_rd,
  input logic       fx_wr,
  input logic       fx_oe,
  input logic       fx_commit,
  input logic [1:0] fx_addr,
  input logic       fx_empty,
  input logic       fx_full,
  input logic       fd_drive
);
  // R2
  rd_gate_chk: assert property (@(posedge if_clk) disable iff (!if_arst_n)
    fx_rd |-> (!fx_empty && fx_oe && fx_addr == 2'b00));

  // R2
  oe_scope_chk: assert property (@(posedge if_clk) disable iff (!if_arst_n)
    fx_oe |-> (fx_addr == 2'b00));

  // R4
  wr_gate_chk: assert property (@(posedge if_clk) disable iff (!if_arst_n)
    fx_wr |-> (!fx_full && fd_drive && fx_addr == 2'b10));

  // R5
  bus_owner_chk: assert property (@(posedge if_clk) disable iff (!if_arst_n)
    !(fx_oe && fd_drive));

  // R6
  addr_settle_chk: assert property (@(posedge if_clk) disable iff (!if_arst_n)
    (fx_addr != $past(fx_addr)) |-> !(fx_rd || fx_wr || fx_commit));

  // R11
  commit_gate_chk: assert property (@(posedge if_clk) disable iff (!if_arst_n)
    fx_commit |-> (!fx_full && fx_addr == 2'b10 && !fx_wr));

  // R11
  commit_single_chk: assert property (@(posedge if_clk) disable iff (!if_arst_n)
    fx_commit |=> !fx_commit);
endmodule

bind usbfifo_bridge usbfifo_bridge_chk u_chk (
  .if_clk(if_clk), .if_arst_n(if_arst_n), .fx_rd(fx_rd), .fx_wr(fx_wr),
  .fx_oe(fx_oe), .fx_commit(fx_commit), .fx_addr(fx_addr),
  .fx_empty(fx_empty), .fx_full(fx_full), .fd_drive(fd_drive)
);

// File: tb/usbfifo_bridge_tb.sv
`timescale 1ns/1ps
module usbfifo_bridge_tb;
  localparam int AW    = 3;
  localparam int RX_LIMIT = 2 * (1 << AW) + 1;

  logic        if_clk = 1'b0, sys_clk = 1'b0;
  logic        if_arst_n = 1'b0, sys_arst_n = 1'b0;
  logic [15:0] fd_in, fd_out;
  logic        fd_drive, fx_rd, fx_wr, fx_oe, fx_commit;
  logic [1:0]  fx_addr;
  logic        fx_empty, fx_full;
  logic [31:0] rx_data, tx_data = '0;
  logic        rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready, commit_req = 1'b0;

  always #17 if_clk  = ~if_clk;
  always #5  sys_clk = ~sys_clk;

  usbfifo_bridge #(.HALF_W(16), .FIFO_AW(AW), .SYNC_STAGES(2)) u_dut (
    .if_clk(if_clk), .if_arst_n(if_arst_n), .sys_clk(sys_clk), .sys_arst_n(sys_arst_n),
    .fd_in(fd_in), .fd_out(fd_out), .fd_drive(fd_drive),
    .fx_rd(fx_rd), .fx_wr(fx_wr), .fx_oe(fx_oe), .fx_commit(fx_commit), .fx_addr(fx_addr),
    .fx_empty(fx_empty), .fx_full(fx_full),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .commit_req(commit_req)
  );

  int n_chk = 0, n_err = 0;

  // ---- chip model: OUT queue, IN capture, flags ----
  logic [15:0] out_mem [0:1023];
  logic [15:0] in_mem  [0:1023];
  int   out_wr = 0, out_rd = 0, in_cnt = 0;
  bit   out_hold = 1'b0, in_full_b = 1'b0, clr_runs = 1'b0;
  int   commit_cnt = 0, commit_at = 0;
  int   v_rd = 0, v_wr = 0, v_bus = 0, v_addr = 0, v_cm = 0;
  int   rd_run = 0, rd_max = 0, wr_run = 0, wr_max = 0;
  logic [1:0] prev_addr = 2'b00;

  assign fx_empty = (out_rd == out_wr) || out_hold;
  assign fx_full  = in_full_b;
  assign fd_in    = fx_oe ? out_mem[out_rd % 1024] : 16'h0000;

  always @(posedge if_clk) begin
    if (if_arst_n) begin
      if (fx_rd) begin
        if (fx_empty || !fx_oe || fx_addr != 2'b00) v_rd <= v_rd + 1;
        else out_rd <= out_rd + 1;
      end
      if (fx_wr) begin
        if (fx_full || !fd_drive || fx_addr != 2'b10) v_wr <= v_wr + 1;
        else begin
          in_mem[in_cnt % 1024] <= fd_out;
          in_cnt <= in_cnt + 1;
        end
      end
      if (fx_commit) begin
        if (fx_full || fx_addr != 2'b10) v_cm <= v_cm + 1;
        commit_cnt <= commit_cnt + 1;
        commit_at  <= in_cnt;
      end
      if (fx_oe && fd_drive) v_bus <= v_bus + 1;
      if (fx_addr != prev_addr && (fx_rd || fx_wr || fx_commit)) v_addr <= v_addr + 1;
      prev_addr <= fx_addr;
      if (fx_rd) begin
        rd_run <= rd_run + 1;
        if (rd_run + 1 > rd_max) rd_max <= rd_run + 1;
      end else rd_run <= 0;
      if (fx_wr) begin
        wr_run <= wr_run + 1;
        if (wr_run + 1 > wr_max) wr_max <= wr_run + 1;
      end else wr_run <= 0;
      if (clr_runs) begin
        rd_max <= 0;
        wr_max <= 0;
      end
    end
  end

  // ---- system-side receive recorder ----
  logic [31:0] rx_got [0:511];
  logic [31:0] tx_sent [0:511];
  int rx_cnt = 0, tx_n = 0, rx_mode = 0;

  initial begin
    forever begin
      @(negedge sys_clk);
      case (rx_mode)
        0:       rx_ready = 1'b1;
        1:       rx_ready = 1'b0;
        default: rx_ready = ($urandom % 3) != 0;
      endcase
      if (rx_ready && rx_valid) begin
        rx_got[rx_cnt] = rx_data;
        rx_cnt++;
      end
    end
  end

  // ---- helpers ----
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rx(input int k);
    return {out_mem[2*k+1], out_mem[2*k]};
  endfunction

  task automatic wait_if(input int n);
    repeat (n) @(negedge if_clk);
  endtask

  task automatic load_out(input int n);
    for (int i = 0; i < n; i++) begin
      out_mem[out_wr % 1024] = 16'($urandom);
      out_wr++;
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    tx_data  = w;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge sys_clk);
    tx_sent[tx_n] = w;
    tx_n++;
    @(negedge sys_clk);
    tx_valid = 1'b0;
  endtask

  task automatic pulse_commit();
    @(negedge sys_clk);
    commit_req = 1'b1;
    @(negedge sys_clk);
    commit_req = 1'b0;
  endtask

  task automatic clear_runs();
    @(negedge if_clk);
    clr_runs = 1'b1;
    @(negedge if_clk);
    clr_runs = 1'b0;
  endtask

  int rx_chk_idx = 0, tx_chk_idx = 0;

  task automatic verify_rx(input string req);
    while (rx_cnt < out_wr / 2) @(negedge sys_clk);
    for (int k = rx_chk_idx; k < rx_cnt; k++)
      chk(rx_got[k] == exp_rx(k), req, "rx word", rx_got[k], exp_rx(k));
    rx_chk_idx = rx_cnt;
  endtask

  task automatic verify_tx(input string req);
    while (in_cnt < 2 * tx_n) @(negedge if_clk);
    for (int k = tx_chk_idx; k < tx_n; k++) begin
      chk(in_mem[2*k] == tx_sent[k][15:0], req, "IN low half", in_mem[2*k], tx_sent[k][15:0]);
      chk(in_mem[2*k+1] == tx_sent[k][31:16], req, "IN high half", in_mem[2*k+1], tx_sent[k][31:16]);
    end
    tx_chk_idx = tx_n;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  // ---- watchdog ----
  initial begin
    repeat (150000) @(posedge sys_clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  // ---- main sequence ----
  bit mix_done = 1'b0;
  int base, c0;

  initial begin
    void'($urandom(32'd51877));
    // R1 reset state
    repeat (4) @(negedge if_clk);
    chk(!fx_rd && !fx_wr && !fx_commit, "R1", "strobes in reset", {fx_rd, fx_wr, fx_commit}, 0);
    chk(!fx_oe && !fd_drive, "R1", "bus enables in reset", {fx_oe, fd_drive}, 0);
    if_arst_n  = 1'b1;
    sys_arst_n = 1'b1;
    wait_if(4);
    chk(!fx_rd && !fx_wr && !fx_commit && !fx_oe && !fd_drive, "R1", "pins after release",
        {fx_rd, fx_wr, fx_commit, fx_oe, fd_drive}, 0);
    chk(!rx_valid, "R1", "rx_valid after release", rx_valid, 0);
    chk(tx_ready, "R1", "tx_ready after release", tx_ready, 1);

    // R7 / R3: directed read burst
    clear_runs();
    load_out(64);
    verify_rx("R3");
    chk(rd_max == 64, "R7", "read run length", rd_max, 64);

    // R8 / R4: directed write burst
    clear_runs();
    @(negedge sys_clk);
    for (int i = 0; i < 32; i++) push_word($urandom);
    verify_tx("R4");
    chk(wr_max == 64, "R8", "write run length", wr_max, 64);

    // R10: receive backpressure limit
    rx_mode = 1;
    repeat (3) @(negedge sys_clk);
    @(negedge if_clk);
    base = out_rd;
    load_out(40);
    wait_if(80);
    chk(out_rd - base == RX_LIMIT, "R10", "halves taken while stalled", out_rd - base, RX_LIMIT);
    chk(rx_valid, "R10", "rx_valid while stalled", rx_valid, 1);
    rx_mode = 0;
    verify_rx("R10");

    // R9: full flag stall
    @(negedge if_clk);
    in_full_b = 1'b1;
    base = in_cnt;
    @(negedge sys_clk);
    for (int i = 0; i < 4; i++) push_word($urandom);
    wait_if(40);
    chk(in_cnt == base, "R9", "halves written while full", in_cnt, base);
    @(negedge if_clk);
    in_full_b = 1'b0;
    verify_tx("R9");

    // R11: packet commit
    @(negedge sys_clk);
    for (int i = 0; i < 3; i++) push_word($urandom);
    verify_tx("R4");
    wait_if(5);
    c0 = commit_cnt;
    in_full_b = 1'b1;
    pulse_commit();
    wait_if(40);
    chk(commit_cnt == c0, "R11", "commit held by full flag", commit_cnt, c0);
    in_full_b = 1'b0;
    wait_if(20);
    chk(commit_cnt == c0 + 1, "R11", "one commit after release", commit_cnt, c0 + 1);
    chk(commit_at == in_cnt, "R11", "commit after last half", commit_at, in_cnt);
    pulse_commit();
    wait_if(20);
    chk(commit_cnt == c0 + 2, "R11", "second commit single", commit_cnt, c0 + 2);

    // mixed random traffic in both directions with flag and stream stalls
    rx_mode = 2;
    fork
      begin
        while (!mix_done) begin
          @(negedge if_clk);
          in_full_b = ($urandom % 5) == 0;
          out_hold  = ($urandom % 6) == 0;
        end
        in_full_b = 1'b0;
        out_hold  = 1'b0;
      end
    join_none
    fork
      begin
        for (int c = 0; c < 24; c++) begin
          @(negedge if_clk);
          load_out(2 * (1 + $urandom % 5));
          wait_if($urandom % 20);
        end
      end
      begin
        @(negedge sys_clk);
        for (int i = 0; i < 60; i++) begin
          push_word($urandom);
          repeat ($urandom % 8) @(negedge sys_clk);
        end
      end
    join
    while (rx_cnt < out_wr / 2 || in_cnt < 2 * tx_n) @(negedge if_clk);
    mix_done = 1'b1;
    wait_if(3);
    verify_rx("R3");
    verify_tx("R9");

    // protocol counters collected over the whole run
    chk(v_rd == 0, "R2", "reads outside empty/oe/addr rule", v_rd, 0);
    chk(v_wr == 0, "R4", "writes outside full/drive/addr rule", v_wr, 0);
    chk(v_bus == 0, "R5", "cycles with both drivers on", v_bus, 0);
    chk(v_addr == 0, "R6", "strobes in address-change cycle", v_addr, 0);
    chk(v_cm == 0, "R11", "commits outside full/addr rule", v_cm, 0);
    chk(rx_cnt == out_wr / 2, "R3", "total rx words", rx_cnt, out_wr / 2);
    chk(in_cnt == 2 * tx_n, "R4", "total IN halves", in_cnt, 2 * tx_n);

    summary();
    $finish;
  end
endmodule